// File: doc/BRIEF.md
# LCD Output-Enable (AC-Bias) Signal Generator

This block drives the ac-bias line of an LCD panel. In active-matrix mode the same line serves as the output-enable line. The block runs on the logic clock. It counts pulses of a line-clock enable that is generated elsewhere, and it flips its output level each time a programmed number of line clocks has passed. It also counts those flips. After a programmed number of flips it raises a one-cycle interrupt pulse, which can be used to pace frame-level software work.

Each control has its own input:

- a divide count that sets the number of line clocks between flips;
- a flip count that sets how many flips make one interrupt;
- a polarity invert;
- a gate that parks the pin at its inactive level.

The block captures the controls only at a flip boundary, or at any time while it is disabled. Reprogramming a running panel therefore never shortens or stretches a half-period. Dropping the enable clears every counter and the output level in the next cycle.

Top module: `acb_gen`

## Requirements
- R1: After reset the pin is 0 and the interrupt is 0. The captured controls reset to divide 1, flip count 0, no inversion and no gating.
- R2: While enabled, the internal level flips on the line-clock pulse that completes the captured divide count D. The flip is visible one clock after that pulse. Logic-clock cycles without a line-clock pulse do not advance the count.
- R3: A divide count of 0 behaves exactly like a divide count of 1, so the level flips on every line-clock pulse.
- R4: With a captured flip count N in 1..15, the interrupt is high for exactly one clock after every Nth flip. The flip counter then starts again from zero.
- R5: A captured flip count of 0 produces no interrupt, whatever number of flips occur.
- R6: The pin equals the internal level XOR the captured invert bit, where invert = 1 means the inverted polarity.
- R7: When the captured gate bit is 1, the pin holds the inactive level, which equals the captured invert bit, and does not follow the internal level.
- R8: One clock after enable is sampled low, the pin is at its inactive level and the interrupt is 0. Counting then starts from zero when enable returns.
- R9: While enabled, new control values are captured only on the line-clock pulse that causes a flip. Between flips, changes on the control inputs have no effect on the pin timing, the polarity, the gating or the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low clears counters and level synchronously |
| line_tick | input | 1 | One-cycle line-clock pulse |
| cfg_period | input | 8 | Line clocks between flips (0 acts as 1) |
| cfg_trans | input | 4 | Flips per interrupt (0 disables the interrupt) |
| cfg_invert | input | 1 | Pin polarity invert |
| cfg_gate | input | 1 | Hold pin at inactive level |
| acb_pin | output | 1 | AC-bias / output-enable pin |
| acb_irq | output | 1 | One-cycle interrupt pulse |

## Verification
The divider is driven with line-clock pulses on every cycle, on every other cycle and in a random pattern. These patterns separate counting of line pulses from counting of logic clocks. Divide counts of 0, 1 and 3 separate the zero-as-one rule from an off-by-one error. A flip count of 3 is run against a flip count of 0 to show both that the interrupt paces correctly and that it can be switched off. Controls are changed in the middle of a half-period, and enable is dropped in the middle of a count, to show that capture happens only at flip boundaries and that the clear is synchronous.

// File: rtl/acb_pkg.sv
package acb_pkg;
    parameter int ACB_PER_W = 8;
    parameter int ACB_TRN_W = 4;

    typedef struct packed {
        logic [ACB_PER_W-1:0] period;
        logic [ACB_TRN_W-1:0] trans;
        logic                 invert;
        logic                 gate;
    } acb_cfg_t;

    localparam acb_cfg_t ACB_CFG_RESET = '{
        period: ACB_PER_W'(1),
        trans:  '0,
        invert: 1'b0,
        gate:   1'b0
    };
endpackage

// File: rtl/acb_cfg_shadow.sv
module acb_cfg_shadow
    import acb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  acb_cfg_t cfg_in,
    output acb_cfg_t cfg_q
);
    typedef struct packed {
        acb_cfg_t cfg;
    } shadow_t;

    shadow_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.cfg = cfg_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cfg <= ACB_CFG_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_q = s_q.cfg;
endmodule

// File: rtl/acb_toggle_div.sv
module acb_toggle_div #(
    parameter int PER_W = acb_pkg::ACB_PER_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             line_tick,
    input  logic [PER_W-1:0] period,
    output logic             toggle,
    output logic             level_q
);
    localparam int CNT_W = PER_W + 1;

    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic             lvl;
    } div_t;

    div_t r_d, r_q;
    logic [CNT_W-1:0] eff_period;
    logic [CNT_W-1:0] cnt_next;
    logic             at_last;

    always_comb begin
        eff_period = (period == '0) ? CNT_W'(1) : {1'b0, period};
        cnt_next   = {1'b0, r_q.cnt} + CNT_W'(1);
        at_last    = (cnt_next >= eff_period);
        toggle     = enable & line_tick & at_last;

        r_d = r_q;
        if (!enable) begin
            r_d.cnt = '0;
            r_d.lvl = 1'b0;
        end else if (line_tick) begin
            if (at_last) begin
                r_d.cnt = '0;
                r_d.lvl = ~r_q.lvl;
            end else begin
                r_d.cnt = cnt_next[PER_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign level_q = r_q.lvl;
endmodule

// File: rtl/acb_trans_cnt.sv
module acb_trans_cnt #(
    parameter int TRN_W = acb_pkg::ACB_TRN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             toggle,
    input  logic [TRN_W-1:0] trans,
    output logic             irq_q
);
    typedef struct packed {
        logic [TRN_W-1:0] tc;
        logic             irq;
    } trn_t;

    trn_t r_d, r_q;
    logic [TRN_W-1:0] tc_inc;

    always_comb begin
        tc_inc = r_q.tc + TRN_W'(1);
        r_d     = r_q;
        r_d.irq = 1'b0;
        if (!enable) begin
            r_d.tc = '0;
        end else if (toggle) begin
            if (trans == '0) begin
                r_d.tc = '0;
            end else if (tc_inc == trans) begin
                r_d.tc  = '0;
                r_d.irq = 1'b1;
            end else begin
                r_d.tc = tc_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign irq_q = r_q.irq;
endmodule

// File: rtl/acb_gen.sv
module acb_gen
    import acb_pkg::*;
#(
    parameter int PER_W = ACB_PER_W,
    parameter int TRN_W = ACB_TRN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             line_tick,
    input  logic [PER_W-1:0] cfg_period,
    input  logic [TRN_W-1:0] cfg_trans,
    input  logic             cfg_invert,
    input  logic             cfg_gate,
    output logic             acb_pin,
    output logic             acb_irq
);
    acb_cfg_t cfg_in;
    acb_cfg_t cfg_q;
    logic     toggle;
    logic     lvl_q;
    logic     cap;

    always_comb begin
        cfg_in.period = cfg_period;
        cfg_in.trans  = cfg_trans;
        cfg_in.invert = cfg_invert;
        cfg_in.gate   = cfg_gate;
        cap           = toggle | ~enable;
    end

    acb_cfg_shadow u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cap),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    acb_toggle_div #(.PER_W(PER_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .line_tick (line_tick),
        .period    (cfg_q.period),
        .toggle    (toggle),
        .level_q   (lvl_q)
    );

    acb_trans_cnt #(.TRN_W(TRN_W)) u_trn (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .toggle (toggle),
        .trans  (cfg_q.trans),
        .irq_q  (acb_irq)
    );

    always_comb begin
        if (cfg_q.gate) begin
            acb_pin = cfg_q.invert;
        end else begin
            acb_pin = lvl_q ^ cfg_q.invert;
        end
    end
endmodule

// File: rtl/acb_gen_chk.sv
module acb_gen_chk
    import acb_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     enable,
    input logic     line_tick,
    input logic     toggle,
    input logic     lvl_q,
    input acb_cfg_t cfg_q,
    input logic     acb_irq
);
    // R2
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !line_tick) |=> $stable(lvl_q));

    // R4
    irq_follows_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acb_irq) |-> (lvl_q != $past(lvl_q)));

    // R5
    no_irq_when_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle && cfg_q.trans == '0) |=> !acb_irq);

    // R8
    clear_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!acb_irq && !lvl_q));

    // R9
    capture_at_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !toggle) |=> $stable(cfg_q));
endmodule

bind acb_gen acb_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .line_tick (line_tick),
    .toggle    (toggle),
    .lvl_q     (lvl_q),
    .cfg_q     (cfg_q),
    .acb_irq   (acb_irq)
);

// File: tb/acb_gen_tb.sv
module acb_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       line_tick = 1'b0;
    logic [7:0] cfg_period = 8'd1;
    logic [3:0] cfg_trans = 4'd0;
    logic       cfg_invert = 1'b0;
    logic       cfg_gate = 1'b0;
    logic       acb_pin;
    logic       acb_irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_cnt = 0, m_lvl = 0, m_tc = 0, m_irq = 0;
    int m_per = 1, m_trn = 0, m_inv = 0, m_gate = 0;

    always #2 clk = ~clk;

    acb_gen u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .line_tick(line_tick),
        .cfg_period(cfg_period), .cfg_trans(cfg_trans), .cfg_invert(cfg_invert),
        .cfg_gate(cfg_gate), .acb_pin(acb_pin), .acb_irq(acb_irq)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog expired: actual %0d cycles, expected under 100000", cyc);
            summary();
            $finish;
        end
    end

    task automatic model_update();
        if (!rst_n) begin
            m_cnt = 0; m_lvl = 0; m_tc = 0; m_irq = 0;
            m_per = 1; m_trn = 0; m_inv = 0; m_gate = 0;
        end else if (!enable) begin
            m_cnt = 0; m_lvl = 0; m_tc = 0; m_irq = 0;
            m_per = cfg_period; m_trn = cfg_trans; m_inv = cfg_invert; m_gate = cfg_gate;
        end else begin
            m_irq = 0;
            if (line_tick) begin
                int eff;
                eff = (m_per == 0) ? 1 : m_per;
                m_cnt++;
                if (m_cnt >= eff) begin
                    m_cnt = 0;
                    m_lvl ^= 1;
                    if (m_trn == 0) m_tc = 0;
                    else begin
                        m_tc++;
                        if (m_tc == m_trn) begin m_tc = 0; m_irq = 1; end
                    end
                    m_per = cfg_period; m_trn = cfg_trans;
                    m_inv = cfg_invert; m_gate = cfg_gate;
                end
            end
        end
    endtask

    function automatic int exp_pin();
        return m_gate ? m_inv : (m_lvl ^ m_inv);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic compare();
        check(cur_req, "pin", int'(acb_pin), exp_pin());
        check(cur_req, "irq", int'(acb_irq), m_irq);
    endtask

    // drives at negedge, model follows the edge, compare at next negedge
    task automatic step(input bit en, input bit tk);
        enable = en;
        line_tick = tk;
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic set_cfg(input int per, input int trn, input bit inv, input bit gt);
        cfg_period = 8'(per); cfg_trans = 4'(trn); cfg_invert = inv; cfg_gate = gt;
    endtask

    initial begin
        int irqs;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        check("R1", "reset pin", int'(acb_pin), 0);
        check("R1", "reset irq", int'(acb_irq), 0);
        rst_n = 1'b1;
        step(0, 0);

        // R2: divide by 3, tick every cycle then every other cycle
        cur_req = "R2";
        set_cfg(3, 0, 0, 0);
        step(0, 0);
        for (int i = 0; i < 24; i++) step(1, 1);
        for (int i = 0; i < 30; i++) step(1, i[0]);

        // R3: divide 0 acts as 1
        cur_req = "R3";
        set_cfg(0, 0, 0, 0);
        step(0, 0);
        for (int i = 0; i < 12; i++) step(1, 1);

        // R4: interrupt every third flip, divide 2
        cur_req = "R4";
        set_cfg(2, 3, 0, 0);
        step(0, 0);
        irqs = 0;
        for (int i = 0; i < 36; i++) begin
            step(1, 1);
            irqs += int'(acb_irq);
        end
        check("R4", "irq count over 18 flips", irqs, 6);

        // R5: flip count 0 never interrupts
        cur_req = "R5";
        set_cfg(1, 0, 0, 0);
        step(0, 0);
        irqs = 0;
        for (int i = 0; i < 40; i++) begin
            step(1, 1);
            irqs += int'(acb_irq);
        end
        check("R5", "irq count with flip count 0", irqs, 0);

        // R6: inversion, requested mid-run, lands at a flip
        cur_req = "R6";
        set_cfg(4, 2, 0, 0);
        step(0, 0);
        for (int i = 0; i < 6; i++) step(1, 1);
        cfg_invert = 1'b1;
        for (int i = 0; i < 20; i++) step(1, 1);

        // R7: gate holds the inactive level
        cur_req = "R7";
        cfg_gate = 1'b1;
        for (int i = 0; i < 20; i++) step(1, 1);
        check("R7", "gated pin equals invert", int'(acb_pin), 1);
        cfg_gate = 1'b0;
        cfg_invert = 1'b0;
        for (int i = 0; i < 10; i++) step(1, 1);

        // R8: disable in the middle of a count
        cur_req = "R8";
        set_cfg(5, 2, 0, 0);
        for (int i = 0; i < 13; i++) step(1, 1);
        step(0, 1);
        check("R8", "pin after disable", int'(acb_pin), 0);
        check("R8", "irq after disable", int'(acb_irq), 0);
        for (int i = 0; i < 25; i++) step(1, 1);

        // R9: controls changed mid half-period are held until the flip
        cur_req = "R9";
        set_cfg(6, 0, 0, 0);
        step(0, 0);
        for (int i = 0; i < 3; i++) step(1, 1);
        set_cfg(2, 1, 1, 0);
        for (int i = 0; i < 2; i++) begin
            step(1, 1);
            check("R9", "pin before flip unchanged", int'(acb_pin), 0);
        end
        for (int i = 0; i < 20; i++) step(1, 1);

        // mixed random traffic, all requirements in play
        cur_req = "R2";
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 16) == 0)
                set_cfg($urandom % 5, $urandom % 4, 1'($urandom), 1'(($urandom % 4) == 0));
            step(($urandom % 20) != 0, 1'($urandom));
        end

        summary();
        $finish;
    end
endmodule